// File: doc/BRIEF.md
# Burst-of-Two Dual-Port Static Memory

This block models a synchronous static memory whose read side and write side are entirely separate: each has its own request strobe and address, write data enters on its own input bus, and read data leaves on its own output bus. There is no shared bidirectional bus, so neither port ever waits for the other. Every access moves a pair of 18-bit words. The first word of a pair lives in one internal array and the second word lives in a companion array, and both are indexed by the same pair address.

A write request presents the first word together with its byte mask on the edge where the request is taken. The second word and its own byte mask follow on the next edge. Each captured word is committed to its array one edge after capture. A read that asks for an address whose write is still in flight gets the in-flight bytes merged into the array contents. The result is that a read sees every write requested on or before its own request edge. The memory depth is a parameter, so the model stays small in simulation.

Top module: `burst2_sram`

## Requirements
- R1: While reset is held, and after it is released, `q_valid` is 0 and `q` is 0 until the first read result.
- R2: A read accepted at edge s drives `q` with the first word of the pair at `rd_addr` after edge s+1, and with the second word after edge s+2. `q_valid` is 1 after both of those edges.
- R3: A write accepted at edge t stores `wd` sampled at edge t as the first word of the pair at `wr_addr`. It stores `wd` sampled at edge t+1 as the second word of the same pair.
- R4: `wbe_n` is active low. Bit 0 enables data bits [8:0] and bit 1 enables data bits [17:9]. A byte whose enable is high is left unchanged in the array.
- R5: The byte mask is sampled separately for each beat, so the first word and the second word of one write may use different masks.
- R6: A read request is ignored at the edge that directly follows an accepted read. No extra result beats appear.
- R7: A write request is ignored at the edge that directly follows an accepted write. Its address and data leave the array unchanged.
- R8: A read returns, byte by byte, the data of every write requested at or before its own request edge, including a write to the same address on the same edge. A write requested after the read edge does not change the returned pair.
- R9: When no result beat is due, `q_valid` is 0 and `q` holds its last value.
- R10: A read and a write requested on the same edge to different addresses are both carried out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all requests are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state and output |
| rd_n | input | 1 | Active-low read request |
| rd_addr | input | ADDR_W | Pair address for a read |
| wr_n | input | 1 | Active-low write request |
| wr_addr | input | ADDR_W | Pair address for a write |
| wd | input | 18 | Write data, first beat on the request edge and second beat on the next edge |
| wbe_n | input | 2 | Active-low byte enables for the current write beat |
| q | output | 18 | Read data |
| q_valid | output | 1 | High while `q` carries a read beat |

## Verification
A read and a write can be requested on the same edge to the same address. In that case the read must take bytes from data that is still waiting to be committed to both arrays. The bench provokes this with partial, differing byte masks on the two beats. Its scoreboard applies the write to a reference array before it computes the expected read pair, so every beat is judged as the byte-wise merge of the old contents and the new data. Requests made during the second beat of a burst are also driven on purpose: a wrongly accepted read leaves a beat the scoreboard did not expect, and a wrongly accepted write shows up when its target address is read back later.

// File: rtl/burst2_sram.sv
module burst2_sram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18,
  parameter int NBYTE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wd,
  input  logic [NBYTE-1:0]  wbe_n,
  output logic [DATA_W-1:0] q,
  output logic              q_valid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BW    = DATA_W / NBYTE;

  logic [DATA_W-1:0] mem0 [DEPTH];
  logic [DATA_W-1:0] mem1 [DEPTH];

  logic              rph1, rph2, wph;
  logic [ADDR_W-1:0] ra_q, wa_q;
  logic              w0_v, w1_v;
  logic [ADDR_W-1:0] w0_a, w1_a;
  logic [DATA_W-1:0] w0_d, w1_d;
  logic [NBYTE-1:0]  w0_m, w1_m;
  logic [DATA_W-1:0] rd0, rd1;
  logic              rgo, wgo, hit0, hit1;

  assign rgo  = !rd_n && !rph1;
  assign wgo  = !wr_n && !wph;
  assign hit0 = w0_v && (w0_a == ra_q);
  assign hit1 = w1_v && (w1_a == ra_q);

  for (genvar b = 0; b < NBYTE; b++) begin : g_fwd
    assign rd0[b*BW +: BW] = (hit0 && w0_m[b]) ? w0_d[b*BW +: BW] : mem0[ra_q][b*BW +: BW];
    assign rd1[b*BW +: BW] = (hit1 && w1_m[b]) ? w1_d[b*BW +: BW] : mem1[ra_q][b*BW +: BW];
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBYTE; b++) begin
      if (w0_v && w0_m[b]) mem0[w0_a][b*BW +: BW] <= w0_d[b*BW +: BW];
      if (w1_v && w1_m[b]) mem1[w1_a][b*BW +: BW] <= w1_d[b*BW +: BW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rph1 <= 1'b0; rph2 <= 1'b0; wph <= 1'b0;
      ra_q <= '0;   wa_q <= '0;
      w0_v <= 1'b0; w0_a <= '0; w0_d <= '0; w0_m <= '0;
      w1_v <= 1'b0; w1_a <= '0; w1_d <= '0; w1_m <= '0;
      q    <= '0;   q_valid <= 1'b0;
    end else begin
      rph1 <= rgo;
      rph2 <= rph1;
      if (rgo) ra_q <= rd_addr;
      wph  <= wgo;
      if (wgo) wa_q <= wr_addr;
      w0_v <= wgo;
      if (wgo) begin
        w0_a <= wr_addr; w0_d <= wd; w0_m <= ~wbe_n;
      end
      w1_v <= wph;
      if (wph) begin
        w1_a <= wa_q; w1_d <= wd; w1_m <= ~wbe_n;
      end
      q_valid <= rph1 || rph2;
      if (rph1)      q <= rd0;
      else if (rph2) q <= rd1;
    end
  end

  // R2
  rd_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !rph1) |=> ##1 q_valid ##1 q_valid);

  // R2
  qv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_valid) |-> $past(!rd_n, 2));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |-> $stable(q));

  // R6
  rd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rph1 && !rd_n) |=> ##1 !rph2);

  // R7
  wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wph && !wr_n) |=> !w0_v);
endmodule

// File: tb/burst2_sram_tb.sv
module burst2_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [17:0]   wd = '0;
  logic [1:0]    wbe_n = 2'b11;
  logic [17:0]   q;
  logic          q_valid;

  int total = 0, bad = 0;
  bit run = 0, seen = 0, done = 0;
  logic [17:0] last_q;
  logic [17:0] bm0 [1<<AW];
  logic [17:0] bm1 [1<<AW];
  logic [17:0] exp_q [$];
  string       tag_q [$];

  burst2_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rd_addr(rd_addr),
    .wr_n(wr_n), .wr_addr(wr_addr), .wd(wd), .wbe_n(wbe_n),
    .q(q), .q_valid(q_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string tag, logic [17:0] act, logic [17:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] merge(logic [17:0] old, logic [17:0] nw, logic [1:0] m);
    logic [17:0] r = old;
    if (m[0]) r[8:0]  = nw[8:0];
    if (m[1]) r[17:9] = nw[17:9];
    return r;
  endfunction

  // two-cycle driver; masks are active high here, driven inverted
  task automatic op(bit do_rd, logic [AW-1:0] ra, bit do_wr, logic [AW-1:0] wa,
                    logic [17:0] d0, logic [1:0] m0, logic [17:0] d1, logic [1:0] m1,
                    bit ign_rd, bit ign_wr, string tag);
    rd_n = !do_rd; rd_addr = ra; wr_n = !do_wr; wr_addr = wa; wd = d0; wbe_n = ~m0;
    if (do_wr) begin
      bm0[wa] = merge(bm0[wa], d0, m0);
      bm1[wa] = merge(bm1[wa], d1, m1);
    end
    if (do_rd) begin
      exp_q.push_back(bm0[ra]); tag_q.push_back(tag);
      exp_q.push_back(bm1[ra]); tag_q.push_back(tag);
    end
    @(negedge clk);
    rd_n = !ign_rd; rd_addr = ra + 5; wr_n = !ign_wr; wr_addr = 9; wd = d1; wbe_n = ~m1;
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1; wbe_n = 2'b11;
  endtask

  always @(negedge clk) begin
    if (rst_n && run) begin
      if (q_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected read beat", q, 'x);
        else begin
          logic [17:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(q === e, t, q, e);
        end
        last_q = q;
        seen = 1;
      end else if (seen) begin
        chk(q === last_q, "R9 idle output hold", q, last_q);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(q_valid === 1'b0, "R1 valid under reset", {17'b0, q_valid}, 18'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(q_valid === 1'b0 && q === '0, "R1 reset state", q, 18'h0);
    run = 1;

    for (int a = 0; a < (1<<AW); a++)
      op(0, 0, 1, a[AW-1:0], 18'h100 + 18'(a), 2'b11, 18'h2A000 + 18'(a), 2'b11, 0, 0, "init");
    repeat (3) @(negedge clk);

    // R2 R3 full write then read
    op(0, 0, 1, 3, 18'h3C0F0, 2'b11, 18'h0F1E2, 2'b11, 0, 0, "R3 write");
    op(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R2 R3 read pair");
    repeat (4) @(negedge clk);

    // R4 R5 partial, per-beat masks
    op(0, 0, 1, 2, 18'h1FFFF, 2'b01, 18'h35555, 2'b10, 0, 0, "R4 mask");
    op(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R4 R5 masked pair");
    repeat (2) @(negedge clk);

    // R8 same-edge forwarding with partial masks
    op(1, 3, 1, 3, 18'h12345, 2'b10, 18'h2ABCD, 2'b01, 0, 0, "R8 same-edge forward");
    // R8 later write not seen by earlier read
    op(1, 4, 0, 0, 0, 0, 0, 0, 0, 0, "R8 before later write");
    op(0, 0, 1, 4, 18'h3FFFF, 2'b11, 18'h00001, 2'b11, 0, 0, "R8 later write");
    op(1, 4, 0, 0, 0, 0, 0, 0, 0, 0, "R8 after later write");
    repeat (3) @(negedge clk);

    // R10 independent addresses
    op(1, 5, 1, 6, 18'h0AAAA, 2'b11, 18'h15555, 2'b11, 0, 0, "R10 read side");
    op(1, 6, 0, 0, 0, 0, 0, 0, 0, 0, "R10 write side");
    repeat (2) @(negedge clk);

    // R6 read request in second beat; R7 write request in second beat (target 9)
    op(1, 7, 1, 8, 18'h01234, 2'b11, 18'h04321, 2'b11, 1, 1, "R6 R7 overlap");
    repeat (3) @(negedge clk);
    op(1, 9, 0, 0, 0, 0, 0, 0, 0, 0, "R7 ignored write target");
    op(1, 8, 0, 0, 0, 0, 0, 0, 0, 0, "R3 overlap write");
    repeat (3) @(negedge clk);

    // mixed back-to-back traffic
    for (int i = 0; i < 60; i++) begin
      logic [AW-1:0] ra, wa;
      ra = AW'($urandom);
      wa = (i % 3 == 0) ? ra : AW'($urandom);
      op(($urandom % 4) != 0, ra, ($urandom % 3) != 0, wa,
         18'($urandom), 2'($urandom), 18'($urandom), 2'($urandom), 0, 0, "R8 R10 mixed");
      if (i % 7 == 0) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all beats returned", 18'(exp_q.size()), 18'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule